// File: doc/BRIEF.md
# Vector Sum Reduction Engine

This engine adds up a long stream of signed integer elements that arrive in chunks of up to `LANES` elements. Each accepted chunk is added position by position into a bank of `LANES` partial sums, so the streaming phase costs one cycle per chunk no matter how wide the chunk is. Every chunk carries its own count of valid elements. Positions at or above that count add nothing, which lets a short tail chunk end the array.

When the chunk flagged as last has been taken, the engine stops accepting input and folds the partial sums as a binary tree. On each cycle the upper half of the active partials is added onto the lower half and the active length halves. After `log2(LANES)` such cycles a single total remains. That total is held on the result port until the consumer takes it. The partials are then cleared and the engine accepts the next array.

Top module: `vector_sum_reduce`

## Requirements
- R1: After reset `in_ready_o` is 1 and `res_valid_o` is 0.
- R2: The result equals the sum of every accepted element, each read as a signed two's complement value of `ELEM_W` bits. Element i of a chunk sits at bits `[i*ELEM_W +: ELEM_W]` of `in_data_i`.
- R3: In a chunk with `in_len_i = n` (0 to `LANES`), only elements 0 to n-1 contribute. Positions n and above add zero, and a chunk with n = 0 adds nothing.
- R4: When the last chunk is accepted at clock edge t, `res_valid_o` is 0 until edge t+log2(`LANES`) and becomes 1 right after that edge.
- R5: `in_ready_o` is 0 from the edge that accepts the last chunk until the result has been accepted.
- R6: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_valid_o` stays 1 and `res_data_o` does not change.
- R7: The edge where `res_valid_o` and `res_ready_i` are both 1 ends the reduction. After that edge `in_ready_o` is 1, `res_valid_o` is 0, and the next array sums from zero.
- R8: All sums wrap modulo 2^`ACC_W`, and `ACC_W` is wider than `ELEM_W`.
- R9: An array made of one chunk that is flagged last gives the same total as the sum of its valid elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A chunk is offered |
| in_ready_o | output | 1 | The engine accepts a chunk |
| in_data_i | input | LANES*ELEM_W | Packed chunk elements, element 0 in the low bits |
| in_len_i | input | $clog2(LANES+1) | Number of valid elements in the chunk |
| in_last_i | input | 1 | This chunk ends the array |
| res_valid_o | output | 1 | The total is available |
| res_ready_i | input | 1 | The consumer takes the total |
| res_data_o | output | ACC_W | The total, modulo 2^ACC_W |

## Verification
The assertions assume that `in_len_i` never exceeds `LANES` while `in_valid_i` is high. They also assume that `res_ready_i` only matters while a result is pending. The stimulus keeps every chunk length between 0 and `LANES`. It varies `res_ready_i` freely, which includes holding it low through whole folding phases and holding it high ahead of time. The bench compares against a model that only tracks the running total and the phase countdown. That model is exercised with full, short and empty chunks, with all-positive runs that force the total to wrap, and with back-to-back arrays.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [1:0] {
    PH_ACC  = 2'd0,
    PH_FOLD = 2'd1,
    PH_DONE = 2'd2
  } vsr_phase_e;
endpackage

// File: rtl/vsr_lane.sv
module vsr_lane #(
  parameter int ELEM_W = 16,
  parameter int ACC_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_en_i,
  input  logic              use_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              fold_en_i,
  input  logic [ACC_W-1:0]  fold_i,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int EXT_W = ACC_W - ELEM_W;

  logic [ACC_W-1:0] elem_ext;
  assign elem_ext = {{EXT_W{elem_i[ELEM_W-1]}}, elem_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sum_o <= '0;
    else if (clr_i)             sum_o <= '0;
    else if (acc_en_i && use_i) sum_o <= sum_o + elem_ext;
    else if (fold_en_i)         sum_o <= sum_o + fold_i;
  end

  assert_lane_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sum_o == '0);
  assert_no_acc_in_fold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && fold_en_i));
endmodule

// File: rtl/vsr_fold_mux.sv
module vsr_fold_mux #(
  parameter int LANES = 8,
  parameter int ACC_W = 20,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic [LANES*ACC_W-1:0] sums_i,
  input  logic [LEN_W-1:0]       half_i,
  output logic [LANES*ACC_W-1:0] fold_o
);
  // lane i below half takes lane i+half; every other lane adds zero
  always_comb begin
    fold_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (LEN_W'(i) < half_i) begin
        for (int j = 0; j < LANES; j++) begin
          if (j == i + int'(half_i)) fold_o[i*ACC_W +: ACC_W] = sums_i[j*ACC_W +: ACC_W];
        end
      end
    end
  end
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int LANES = 8,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic             res_ready_i,
  output logic             in_ready_o,
  output logic             acc_en_o,
  output logic             fold_en_o,
  output logic [LEN_W-1:0] half_o,
  output logic             clr_o,
  output logic             res_valid_o
);
  vsr_phase_e phase_q;

  assign in_ready_o  = (phase_q == PH_ACC);
  assign acc_en_o    = in_valid_i && in_ready_o;
  assign fold_en_o   = (phase_q == PH_FOLD);
  assign res_valid_o = (phase_q == PH_DONE);
  assign clr_o       = res_valid_o && res_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACC;
      half_o  <= '0;
    end else begin
      unique case (phase_q)
        PH_ACC: if (acc_en_o && in_last_i) begin
          half_o  <= LEN_W'(LANES / 2);
          phase_q <= (LANES == 1) ? PH_DONE : PH_FOLD;
        end
        PH_FOLD: begin
          half_o <= half_o >> 1;
          if (half_o == LEN_W'(1)) phase_q <= PH_DONE;
        end
        PH_DONE: if (res_ready_i) phase_q <= PH_ACC;
        default: phase_q <= PH_ACC;
      endcase
    end
  end

  assert_fold_pow2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_en_o |-> $countones(half_o) == 1);
  assert_fold_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold_en_o && half_o == LEN_W'(1)) |=> res_valid_o);
endmodule

// File: rtl/vector_sum_reduce.sv
module vector_sum_reduce #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16,
  parameter int ACC_W  = 20,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [LANES*ELEM_W-1:0] in_data_i,
  input  logic [LEN_W-1:0]        in_len_i,
  input  logic                    in_last_i,
  output logic                    res_valid_o,
  input  logic                    res_ready_i,
  output logic [ACC_W-1:0]        res_data_o
);
  logic             acc_en, fold_en, clr;
  logic [LEN_W-1:0] half;
  logic [LANES*ACC_W-1:0] sums, folds;

  vsr_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .res_ready_i(res_ready_i), .in_ready_o(in_ready_o), .acc_en_o(acc_en),
    .fold_en_o(fold_en), .half_o(half), .clr_o(clr), .res_valid_o(res_valid_o)
  );

  vsr_fold_mux #(.LANES(LANES), .ACC_W(ACC_W)) u_fold (
    .sums_i(sums), .half_i(half), .fold_o(folds)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vsr_lane #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .acc_en_i(acc_en),
      .use_i(LEN_W'(g) < in_len_i), .elem_i(in_data_i[g*ELEM_W +: ELEM_W]),
      .fold_en_i(fold_en), .fold_i(folds[g*ACC_W +: ACC_W]),
      .sum_o(sums[g*ACC_W +: ACC_W])
    );
  end

  assign res_data_o = sums[ACC_W-1:0];

  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> in_len_i <= LEN_W'(LANES));
  assert_busy_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o);
  assert_no_ready_with_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !in_ready_o);
  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> (in_ready_o && !res_valid_o));
  initial assert_acc_wider_R8: assert (ACC_W > ELEM_W);
endmodule

// File: tb/vector_sum_reduce_bench.sv
module vector_sum_reduce_bench;
  localparam int LANES  = 8;
  localparam int ELEM_W = 16;
  localparam int ACC_W  = 20;
  localparam int LEN_W  = $clog2(LANES + 1);
  localparam int STEPS  = $clog2(LANES);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, res_ready = 1;
  logic [LANES*ELEM_W-1:0] in_data = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic in_ready, res_valid;
  logic [ACC_W-1:0] res_data;

  int checks = 0, bad = 0, cycles = 0;
  string cur_tag = "R2";

  // model state
  longint m_sum = 0;
  int m_phase = 0, m_cnt = 0;

  always #5 clk = ~clk;

  vector_sum_reduce #(.LANES(LANES), .ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_vector_sum_reduce (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_len_i(in_len), .in_last_i(in_last),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      case (m_phase)
        0: if (in_valid) begin
          for (int i = 0; i < LANES; i++)
            if (i < int'(in_len)) m_sum += longint'($signed(in_data[i*ELEM_W +: ELEM_W]));
          if (in_last) begin
            m_cnt = STEPS;
            m_phase = (STEPS == 0) ? 2 : 1;
          end
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) m_phase = 2;
        end
        default: if (res_ready) begin
          m_phase = 0;
          m_sum = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (m_phase == 0), "R5", longint'(in_ready), longint'(m_phase == 0));
      check(res_valid == (m_phase == 2), "R4", longint'(res_valid), longint'(m_phase == 2));
      if (m_phase == 2) begin
        logic [ACC_W-1:0] exp_v;
        exp_v = m_sum[ACC_W-1:0];
        check(res_data == exp_v, cur_tag, longint'(res_data), longint'(exp_v));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic send(input logic [LANES*ELEM_W-1:0] d, input int len, input bit last);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_len = LEN_W'(len); in_last = last;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  function automatic logic [LANES*ELEM_W-1:0] rnd_chunk();
    logic [LANES*ELEM_W-1:0] d;
    for (int i = 0; i < LANES; i++) d[i*ELEM_W +: ELEM_W] = ELEM_W'($urandom);
    return d;
  endfunction

  task automatic wait_done(input int stall);
    while (!res_valid) @(negedge clk);
    if (stall > 0) begin
      res_ready = 0;
      repeat (stall) @(negedge clk);
      res_ready = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    res_ready = 1;
    #12;
    check(in_ready == 1 && res_valid == 0, "R1", longint'({in_ready, res_valid}), 2);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1 && res_valid == 0, "R1", longint'({in_ready, res_valid}), 2);

    // R9 single chunk
    cur_tag = "R9";
    send(rnd_chunk(), LANES, 1);
    wait_done(0);

    // R2 several full chunks of random signed data
    cur_tag = "R2";
    for (int k = 0; k < 5; k++) send(rnd_chunk(), LANES, k == 4);
    wait_done(0);

    // R3 short and empty chunks
    cur_tag = "R3";
    send(rnd_chunk(), 3, 0);
    send(rnd_chunk(), 0, 0);
    send(rnd_chunk(), LANES, 0);
    send(rnd_chunk(), 1, 1);
    wait_done(0);
    send(rnd_chunk(), 0, 1);
    wait_done(0);

    // R8 wrap with max positive and max negative runs
    cur_tag = "R8";
    for (int k = 0; k < 40; k++) send({LANES{16'h7fff}}, LANES, k == 39);
    wait_done(0);
    for (int k = 0; k < 40; k++) send({LANES{16'h8000}}, LANES, k == 39);
    wait_done(0);

    // R6 stalled result, with ready low before the fold starts too
    cur_tag = "R6";
    res_ready = 0;
    send(rnd_chunk(), 5, 0);
    send(rnd_chunk(), LANES, 1);
    wait_done(6);

    // R7 back-to-back arrays, new sum starts from zero
    cur_tag = "R7";
    for (int a = 0; a < 20; a++) begin
      int n = 1 + int'($urandom_range(0, 4));
      for (int k = 0; k < n; k++)
        send(rnd_chunk(), int'($urandom_range(0, LANES)), k == n - 1);
      wait_done(a % 3);
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule